// File: doc/BRIEF.md
# Power-Mode Sequencer with Multi-Source Wakeup

This block moves a device between three conditions: full operation, a light CPU sleep, and a deep power-save state. While running, a wait-for-interrupt style indication puts the CPU to sleep. In sleep the CPU and memory clock is gated, the peripheral clock keeps running, and any interrupt ends the sleep. A software request starts a two-step entry into deep power save. First both clock gates close. One cycle later the core, I/O, non-volatile memory, motor-driver and sensing domain enables drop, together with the fast oscillator enable.

Three independently enabled conditions end power save: an RF carrier being present, an external wake pin at a programmable active level, and a standby counter. The counter counts slow-clock tick strobes from zero, starting at power-save entry. When a wake occurs, the oscillator and domains are switched on at once. The clocks stay gated for a fixed settle period, and a status vector records which conditions fired. The block also produces a fast-clock enable strobe divided by 1, 2, 4 or 8. It holds the software-owned on/off settings of the memory and sensing domains that apply while the device runs.

All logic sits in the always-on clock domain. The analog regulators and oscillators are driven through the enable outputs. The carrier-detect and wake-pin inputs are asynchronous and pass through a two-stage synchronizer.

Top module: `pwrmode_ctrl`

## Requirements
- R1: After reset the block is in full operation: in_psave=0, both clock gates 0, fosc_en=1, the core, I/O, memory and motor-driver domains on, the sensing domain off, and wake_src=0.
- R2: Deep power save is entered only from full operation on psave_req. The edge that samples the request gates the clocks while keeping the domains on. The following edge sets in_psave=1. A request made during sleep has no effect.
- R3: wake_en bit 0 enables the RF-field condition, bit 1 the wake-pin condition and bit 2 the standby-timer condition. A condition whose bit is 0 never ends power save. field_in and wake_pin reach the wake logic through two sync stages, so power save ends on the third rising edge after the input changes.
- R4: The wake pin is active when it equals wake_pol (1 means active high, 0 means active low).
- R5: The standby counter is cleared on power-save entry and counts slow_tick strobes only while in power save. When its count reaches stby_limit, power save ends on the next edge. Ticks seen before entry do not count.
- R6: From full operation, sleep_req gates only the CPU/memory clock on the next edge, with the peripheral clock, oscillator and domains left on. irq_any ends sleep on the next edge.
- R7: On power-save entry the clock gates are asserted one cycle before any domain enable or fosc_en drops.
- R8: In power save fosc_en, pd_core_en, pd_io_en, pd_nvm_en, pd_hb_en and pd_sense_en are all 0.
- R9: On a wake, fosc_en and the domain enables return on the same edge that leaves power save. Both clock gates stay asserted for exactly SETTLE cycles and then release. wake_src takes the enabled conditions that fired (same bit positions as wake_en) and holds them until the next wake.
- R10: While not in power save, pd_nvm_en and pd_sense_en follow software bits written with dom_wr (reset values 1 and 0). The written values survive a power-save cycle.
- R11: pd_nfc_en equals the synchronized field_in in every mode.
- R12: Outside power save, fclk_tick pulses once every 2^div_sel cycles (div_sel 0..3 gives 1, 2, 4, 8). In power save it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psave_req | input | 1 | Software request for deep power save |
| sleep_req | input | 1 | CPU wait-for-interrupt/event indication |
| irq_any | input | 1 | Any pending interrupt |
| wake_en | input | 3 | Wake enables: [0] field, [1] pin, [2] timer |
| wake_pol | input | 1 | Active level of the wake pin |
| wake_pin | input | 1 | External wake pin (asynchronous) |
| field_in | input | 1 | RF carrier detected (asynchronous) |
| slow_tick | input | 1 | One-cycle strobe per slow-clock tick |
| stby_limit | input | TMR_W | Standby timer limit in slow ticks |
| dom_wr | input | 1 | Write strobe for software domain bits |
| dom_nvm_on | input | 1 | Memory domain on while operating |
| dom_sense_on | input | 1 | Sensing domain on while operating |
| div_sel | input | DIV_W | Fast clock divide select (log2) |
| in_psave | output | 1 | Deep power save active |
| cpu_clk_gate | output | 1 | 1 gates the CPU/memory clock |
| per_clk_gate | output | 1 | 1 gates the peripheral clock |
| fosc_en | output | 1 | Fast oscillator enable |
| pd_core_en | output | 1 | Core domain enable |
| pd_io_en | output | 1 | I/O domain enable |
| pd_nvm_en | output | 1 | Non-volatile memory domain enable |
| pd_hb_en | output | 1 | Motor-driver domain enable |
| pd_sense_en | output | 1 | Sensing domain enable |
| pd_nfc_en | output | 1 | RF interface domain enable |
| fclk_tick | output | 1 | Divided fast-clock enable strobe |
| wake_src | output | 3 | Conditions that caused the last wake |

## Verification
The bench runs all eight enable combinations against each of the three wake conditions. A design that ignores an enable bit, or that wires a condition to the wrong bit, either wakes when it should stay down or records the wrong wake_src bit. It sweeps the standby limit and feeds slow ticks before entry. This exposes a counter that is off by one, is never cleared on entry, or counts during operation. It times the wake-pin and field paths to the exact edge, checks that the two-step entry keeps the domains up while the clocks are already gated, and measures the settle window to the cycle, so that an early clock release or a reversed ordering shows up. It also counts divider strobes for every select value, checks the active-low polarity, and checks that the domain settings survive a power-save cycle.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_SLEEP = 3'd1,
    ST_ENTER = 3'd2,
    ST_PSAVE = 3'd3,
    ST_WAKE  = 3'd4
  } pm_state_e;

  localparam int WK_N     = 3;
  localparam int WK_FIELD = 0;
  localparam int WK_PIN   = 1;
  localparam int WK_TMR   = 2;
endpackage

// File: rtl/pwrmode_sync.sv
module pwrmode_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/pwrmode_stby_tmr.sv
module pwrmode_stby_tmr #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             tick,
  input  logic [TMR_W-1:0] limit,
  output logic             expired
);
  logic [TMR_W-1:0] cnt_q, cnt_d;

  assign expired = (cnt_q >= limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                          cnt_d = '0;
    else if (run && tick && !expired) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pwrmode_clkdiv.sv
module pwrmode_clkdiv #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] sel,
  output logic             tick
);
  localparam int CW = (1 << DIV_W) - 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] mask;

  assign mask = ~({CW{1'b1}} << sel);
  assign tick = run && ((cnt_q & mask) == '0);

  always_comb begin
    if (run) cnt_d = cnt_q + 1'b1;
    else     cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pwrmode_fsm.sv
module pwrmode_fsm
  import pwrmode_pkg::*;
#(
  parameter int SETTLE = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            psave_req,
  input  logic            sleep_req,
  input  logic            irq_any,
  input  logic [WK_N-1:0] wk_raw,
  input  logic [WK_N-1:0] wk_en,
  output pm_state_e       state,
  output logic [WK_N-1:0] wk_src
);
  localparam int SW = $clog2(SETTLE + 1);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE - 1);

  pm_state_e       state_q, state_d;
  logic [SW-1:0]   settle_q, settle_d;
  logic [WK_N-1:0] src_q, src_d;
  logic [WK_N-1:0] hit;

  assign hit = wk_raw & wk_en;

  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    unique case (state_q)
      ST_RUN: begin
        if (psave_req)      state_d = ST_ENTER;
        else if (sleep_req) state_d = ST_SLEEP;
      end
      ST_SLEEP: if (irq_any) state_d = ST_RUN;
      ST_ENTER: state_d = ST_PSAVE;
      ST_PSAVE: begin
        if (|hit) begin
          state_d = ST_WAKE;
          src_d   = hit;
        end
      end
      ST_WAKE: if (settle_q == SETTLE_LAST) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_comb begin
    if (state_q == ST_WAKE) settle_d = settle_q + 1'b1;
    else                    settle_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      settle_q <= '0;
      src_q    <= '0;
    end else begin
      state_q  <= state_d;
      settle_q <= settle_d;
      src_q    <= src_d;
    end
  end

  assign state  = state_q;
  assign wk_src = src_q;
endmodule

// File: rtl/pwrmode_ctrl.sv
module pwrmode_ctrl
  import pwrmode_pkg::*;
#(
  parameter int TMR_W       = 16,
  parameter int SETTLE      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psave_req,
  input  logic             sleep_req,
  input  logic             irq_any,
  input  logic [2:0]       wake_en,
  input  logic             wake_pol,
  input  logic             wake_pin,
  input  logic             field_in,
  input  logic             slow_tick,
  input  logic [TMR_W-1:0] stby_limit,
  input  logic             dom_wr,
  input  logic             dom_nvm_on,
  input  logic             dom_sense_on,
  input  logic [DIV_W-1:0] div_sel,
  output logic             in_psave,
  output logic             cpu_clk_gate,
  output logic             per_clk_gate,
  output logic             fosc_en,
  output logic             pd_core_en,
  output logic             pd_io_en,
  output logic             pd_nvm_en,
  output logic             pd_hb_en,
  output logic             pd_sense_en,
  output logic             pd_nfc_en,
  output logic             fclk_tick,
  output logic [2:0]       wake_src
);
  pm_state_e       state;
  logic [1:0]      async_in, async_s;
  logic            field_s, pin_s;
  logic            tmr_exp;
  logic [WK_N-1:0] wk_raw;
  logic            nvm_cfg_q, nvm_cfg_d;
  logic            sense_cfg_q, sense_cfg_d;
  logic            powered;

  assign async_in = {wake_pin, field_in};

  pwrmode_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (async_in),
    .d_out (async_s)
  );

  assign field_s = async_s[0];
  assign pin_s   = async_s[1];

  pwrmode_stby_tmr #(.TMR_W(TMR_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (state == ST_ENTER),
    .run     (state == ST_PSAVE),
    .tick    (slow_tick),
    .limit   (stby_limit),
    .expired (tmr_exp)
  );

  always_comb begin
    wk_raw           = '0;
    wk_raw[WK_FIELD] = field_s;
    wk_raw[WK_PIN]   = (pin_s == wake_pol);
    wk_raw[WK_TMR]   = tmr_exp;
  end

  pwrmode_fsm #(.SETTLE(SETTLE)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .psave_req (psave_req),
    .sleep_req (sleep_req),
    .irq_any   (irq_any),
    .wk_raw    (wk_raw),
    .wk_en     (wake_en),
    .state     (state),
    .wk_src    (wake_src)
  );

  always_comb begin
    nvm_cfg_d   = nvm_cfg_q;
    sense_cfg_d = sense_cfg_q;
    if (dom_wr) begin
      nvm_cfg_d   = dom_nvm_on;
      sense_cfg_d = dom_sense_on;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nvm_cfg_q   <= 1'b1;
      sense_cfg_q <= 1'b0;
    end else begin
      nvm_cfg_q   <= nvm_cfg_d;
      sense_cfg_q <= sense_cfg_d;
    end
  end

  assign powered      = (state != ST_PSAVE);
  assign in_psave     = (state == ST_PSAVE);
  assign cpu_clk_gate = (state != ST_RUN);
  assign per_clk_gate = (state == ST_ENTER) || (state == ST_PSAVE) || (state == ST_WAKE);
  assign fosc_en      = powered;
  assign pd_core_en   = powered;
  assign pd_io_en     = powered;
  assign pd_hb_en     = powered;
  assign pd_nvm_en    = powered && nvm_cfg_q;
  assign pd_sense_en  = powered && sense_cfg_q;
  assign pd_nfc_en    = field_s;

  pwrmode_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (powered),
    .sel   (div_sel),
    .tick  (fclk_tick)
  );
endmodule

// File: rtl/pwrmode_chk.sv
module pwrmode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       psave_req,
  input logic [2:0] wake_en,
  input logic       in_psave,
  input logic       cpu_clk_gate,
  input logic       per_clk_gate,
  input logic       fosc_en,
  input logic       pd_core_en,
  input logic       pd_sense_en,
  input logic       fclk_tick,
  input logic [2:0] wake_src
);
  // R2
  a_r2_entry_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_psave) |-> $past(psave_req, 2));

  // R8
  a_r8_psave_off: assert property (@(posedge clk) disable iff (!rst_n)
    in_psave |-> (!fosc_en && !pd_core_en && !pd_sense_en && cpu_clk_gate && per_clk_gate));

  // R7
  a_r7_gate_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_core_en) |-> ($past(cpu_clk_gate) && $past(per_clk_gate)));

  // R3
  a_r3_no_en_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (in_psave && (wake_en == 3'b000)) |=> in_psave);

  // R9
  a_r9_release_powered: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(per_clk_gate) |-> ($past(fosc_en) && $past(pd_core_en)));

  // R9
  a_r9_src_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fosc_en) |-> (wake_src != 3'b000));

  // R6
  a_r6_sleep_powered: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_gate && !per_clk_gate) |-> (pd_core_en && fosc_en));

  // R12
  a_r12_no_tick_psave: assert property (@(posedge clk) disable iff (!rst_n)
    in_psave |-> !fclk_tick);
endmodule

bind pwrmode_ctrl pwrmode_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .psave_req    (psave_req),
  .wake_en      (wake_en),
  .in_psave     (in_psave),
  .cpu_clk_gate (cpu_clk_gate),
  .per_clk_gate (per_clk_gate),
  .fosc_en      (fosc_en),
  .pd_core_en   (pd_core_en),
  .pd_sense_en  (pd_sense_en),
  .fclk_tick    (fclk_tick),
  .wake_src     (wake_src)
);

// File: tb/sim_pwrmode_ctrl.sv
`timescale 1ns/1ps
module sim_pwrmode_ctrl;
  localparam int TMR_W  = 8;
  localparam int SETTLE = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic psave_req, sleep_req, irq_any;
  logic [2:0] wake_en;
  logic wake_pol, wake_pin, field_in, slow_tick;
  logic [TMR_W-1:0] stby_limit;
  logic dom_wr, dom_nvm_on, dom_sense_on;
  logic [1:0] div_sel;
  logic in_psave, cpu_clk_gate, per_clk_gate, fosc_en;
  logic pd_core_en, pd_io_en, pd_nvm_en, pd_hb_en, pd_sense_en, pd_nfc_en;
  logic fclk_tick;
  logic [2:0] wake_src;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pwrmode_ctrl #(.TMR_W(TMR_W), .SETTLE(SETTLE)) u0 (
    .clk(clk), .rst_n(rst_n), .psave_req(psave_req), .sleep_req(sleep_req),
    .irq_any(irq_any), .wake_en(wake_en), .wake_pol(wake_pol), .wake_pin(wake_pin),
    .field_in(field_in), .slow_tick(slow_tick), .stby_limit(stby_limit),
    .dom_wr(dom_wr), .dom_nvm_on(dom_nvm_on), .dom_sense_on(dom_sense_on),
    .div_sel(div_sel), .in_psave(in_psave), .cpu_clk_gate(cpu_clk_gate),
    .per_clk_gate(per_clk_gate), .fosc_en(fosc_en), .pd_core_en(pd_core_en),
    .pd_io_en(pd_io_en), .pd_nvm_en(pd_nvm_en), .pd_hb_en(pd_hb_en),
    .pd_sense_en(pd_sense_en), .pd_nfc_en(pd_nfc_en), .fclk_tick(fclk_tick),
    .wake_src(wake_src)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    psave_req = 0; sleep_req = 0; irq_any = 0; wake_en = 3'b000;
    wake_pol = 1; wake_pin = 0; field_in = 0; slow_tick = 0;
    stby_limit = 8'd3; dom_wr = 0; dom_nvm_on = 0; dom_sense_on = 0; div_sel = 0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  function automatic int pwr_vec();
    return {fosc_en, pd_core_en, pd_io_en, pd_hb_en};
  endfunction

  task automatic enter_psave();
    psave_req = 1'b1;
    step(1);
    psave_req = 1'b0;
    // R7: gated, still powered
    chk(cpu_clk_gate && per_clk_gate && pwr_vec() == 4'hF && !in_psave,
        "R7 entry step", {cpu_clk_gate, per_clk_gate, pwr_vec()}, 6'h3F);
    step(1);
    chk(in_psave && pwr_vec() == 0 && !pd_nvm_en && !pd_sense_en,
        "R8 psave outputs", {in_psave, pwr_vec()}, 5'h10);
  endtask

  task automatic check_settle(input string tag);
    step(SETTLE - 1);
    chk(cpu_clk_gate && per_clk_gate && fosc_en && pd_core_en, tag, {cpu_clk_gate, fosc_en}, 2'b11);
    step(1);
    chk(!cpu_clk_gate && !per_clk_gate, tag, {cpu_clk_gate, per_clk_gate}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(!in_psave && !cpu_clk_gate && !per_clk_gate && pwr_vec() == 4'hF
        && pd_nvm_en && !pd_sense_en && wake_src == 0,
        "R1 reset state", {in_psave, cpu_clk_gate, pwr_vec(), pd_nvm_en, pd_sense_en}, 7'b0011110);

    // R3 sweep: every enable combination against every source
    for (int en = 0; en < 8; en++) begin
      for (int src = 0; src < 3; src++) begin
        do_reset();
        wake_en = en[2:0];
        stby_limit = 8'd3;
        enter_psave();
        if (src == 2) begin
          for (int k = 0; k < 2; k++) begin
            slow_tick = 1; step(1); slow_tick = 0; step(1);
          end
          chk(in_psave, "R5 before limit", in_psave, 1);
          slow_tick = 1; step(1); slow_tick = 0;
          chk(in_psave, "R5 at limit edge", in_psave, 1);
          step(1);
        end else begin
          if (src == 0) field_in = 1; else wake_pin = 1;
          step(2);
          chk(in_psave, "R3 sync latency", in_psave, 1);
          step(1);
        end
        if (en[src]) begin
          chk(!in_psave && fosc_en && pd_core_en && cpu_clk_gate,
              "R9 wake powers first", {in_psave, fosc_en, cpu_clk_gate}, 3'b011);
          chk(wake_src == (3'b001 << src), "R9 wake_src", wake_src, 3'b001 << src);
          check_settle("R9 settle window");
        end else begin
          step(4);
          chk(in_psave && pwr_vec() == 0, "R3 disabled source ignored",
              {in_psave, pwr_vec()}, 5'h10);
        end
      end
    end

    // R4 active-low wake pin
    do_reset();
    wake_en = 3'b010; wake_pol = 0; wake_pin = 1;
    step(3);
    enter_psave();
    step(5);
    chk(in_psave, "R4 inactive high level ignored", in_psave, 1);
    wake_pin = 0;
    step(3);
    chk(!in_psave && wake_src == 3'b010, "R4 active low wakes", {in_psave, wake_src}, 4'b0010);

    // R5 limit sweep, ticks before entry do not count
    for (int lim = 1; lim <= 5; lim++) begin
      do_reset();
      wake_en = 3'b100; stby_limit = lim[TMR_W-1:0];
      for (int k = 0; k < 6; k++) begin
        slow_tick = 1; step(1); slow_tick = 0; step(1);
      end
      enter_psave();
      for (int k = 0; k < lim; k++) begin
        chk(in_psave, "R5 still counting", in_psave, 1);
        slow_tick = 1; step(1); slow_tick = 0; step(1);
      end
      chk(!in_psave && wake_src == 3'b100, "R5 expiry at limit", {in_psave, wake_src}, 4'b0100);
    end

    // R6 sleep and R2 request ignored in sleep
    do_reset();
    div_sel = 0;
    sleep_req = 1; step(1); sleep_req = 0;
    chk(cpu_clk_gate && !per_clk_gate && pwr_vec() == 4'hF, "R6 sleep gating",
        {cpu_clk_gate, per_clk_gate, pwr_vec()}, 6'h2F);
    chk(fclk_tick, "R6 peripheral clock runs", fclk_tick, 1);
    psave_req = 1; step(2); psave_req = 0;
    chk(pd_core_en && !per_clk_gate && !in_psave, "R2 request in sleep ignored",
        {pd_core_en, per_clk_gate}, 2'b10);
    irq_any = 1; step(1); irq_any = 0;
    chk(!cpu_clk_gate, "R6 irq ends sleep", cpu_clk_gate, 0);

    // R10 software domain bits across power save; R11 field domain
    do_reset();
    dom_wr = 1; dom_nvm_on = 0; dom_sense_on = 1; step(1); dom_wr = 0;
    chk(!pd_nvm_en && pd_sense_en, "R10 written bits", {pd_nvm_en, pd_sense_en}, 2'b01);
    wake_en = 3'b000;
    enter_psave();
    field_in = 1;
    step(2);
    chk(pd_nfc_en && in_psave && !pd_core_en, "R11 field domain in psave",
        {pd_nfc_en, in_psave, pd_core_en}, 3'b110);
    wake_en = 3'b001;
    step(1);
    chk(!in_psave, "R3 field wake", in_psave, 0);
    check_settle("R9 settle after field");
    chk(!pd_nvm_en && pd_sense_en, "R10 bits survive", {pd_nvm_en, pd_sense_en}, 2'b01);
    field_in = 0; step(2);
    chk(!pd_nfc_en, "R11 field off", pd_nfc_en, 0);

    // R12 divider sweep and silence in power save
    for (int d = 0; d < 4; d++) begin
      int cnt;
      div_sel = d[1:0];
      step(2);
      cnt = 0;
      for (int k = 0; k < 16; k++) begin
        if (fclk_tick) cnt++;
        step(1);
      end
      chk(cnt == (16 >> d), "R12 divide ratio", cnt, 16 >> d);
    end
    wake_en = 3'b000;
    enter_psave();
    begin
      int cnt;
      cnt = 0;
      for (int k = 0; k < 16; k++) begin
        if (fclk_tick) cnt++;
        step(1);
      end
      chk(cnt == 0, "R12 no ticks in psave", cnt, 0);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule